// File: doc/BRIEF.md
# Dual-Rail Hysteresis Register Stage

This block is one register stage of a delay-insensitive pipeline. Every logical bit travels on a pair of rails. The stage alternates between two phases. In the first, a wavefront of valid code words arrives. In the second, the wires fall back to the all-zero spacer. Each rail is held by a hysteresis gate. The gate turns on when its incoming rail and the downstream request are both high. It turns off only when both are low. A word captured in the gates therefore stays put until the next stage has asked for the spacer.

A completion network watches the held word. An OR of the two rails marks each bit as present. A C-element across all the per-bit marks then raises the acknowledge once every bit holds a code word. It lowers the acknowledge once every bit is back at the spacer. The request sent upstream is the inverse of that acknowledge. Because the design must be synthesizable, the state-holding gates are modelled as flip-flops on a fast sampling clock. Each gate and the completion element therefore take one clock to respond.

Top module: `dr_hold_stage`

## Requirements
- R1: While reset is low at a clock edge, every output rail becomes 0, `ack` becomes 0, `up_req` becomes 1 and `pair_err` becomes 0.
- R2: A logical bit of value v is carried as rail1 = v, rail0 = not v. When `dn_req` is 1, each input rail at 1 sets its held rail one clock later. When the whole input word is a code word, the held word therefore equals it one clock later.
- R3: While `dn_req` is 0, an input rail at 1 does not set its held rail. The held word stays at the spacer when it was the spacer.
- R4: A held rail clears one clock after a cycle in which both its input rail and `dn_req` are 0. While `dn_req` is 1, a spacer at the input leaves the held word unchanged.
- R5: `ack` rises one clock after a cycle in which every bit of the held word has one rail high. It does not rise while any held bit is still at the spacer.
- R6: `ack` falls one clock after a cycle in which every held rail is 0. It stays high while any held bit still carries a code word.
- R7: `up_req` is always the inverse of `ack`.
- R8: An input pair with both rails at 1 sets `pair_err` one clock later. `pair_err` then stays at 1 until reset.
- R9: A held rail rises only after a cycle with `dn_req` at 1, and falls only after a cycle with `dn_req` at 0. So it makes at most one transition per phase.
- R10: A partially arrived wavefront is captured bit by bit. The held bits that have arrived show their values while the others stay at the spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that emulates the gate hysteresis |
| rst_n | input | 1 | Synchronous reset, active low |
| up_rail0 | input | W | Incoming rail0 of each bit |
| up_rail1 | input | W | Incoming rail1 of each bit |
| dn_req | input | 1 | Request from the next stage: 1 asks for a code word, 0 asks for the spacer |
| out_rail0 | output | W | Held rail0 of each bit |
| out_rail1 | output | W | Held rail1 of each bit |
| ack | output | 1 | Completion of the held word |
| up_req | output | 1 | Request to the previous stage, the inverse of `ack` |
| pair_err | output | 1 | Sticky flag for an illegal both-rails-high input pair |

## Verification
The hardest states to reach are the mixed wavefronts. In these, some held bits carry a code word while the rest are at the spacer, and the acknowledge must keep its old value. A free-running handshake moves whole words at once, so it rarely produces such states. Directed steps therefore drive half a word with the request in each polarity, and drain half a word while the rest is still held. A randomized producer and consumer pair then run the four-phase handshake with random delays. Every word that leaves the stage is matched against the order in which words entered it.

// File: rtl/dr_pkg.sv
// Shared helpers for the dual-rail stage.
// Assumes: state-holding gates are emulated as registers on a sampling clock.
package dr_pkg;
    // Next state of a hysteresis element: set wins, clear drops it, otherwise hold.
    function automatic logic hold_next(input logic set_all, input logic clr_all, input logic cur);
        if (set_all)
            return 1'b1;
        else if (clr_all)
            return 1'b0;
        else
            return cur;
    endfunction
endpackage

// File: rtl/dr_th22_bank.sv
// Bank of W two-input hysteresis gates, one per rail of a rail group.
// Each gate sets when its data input and the enable are both 1 and clears when
// both are 0. Assumes a synchronous active-low reset to 0.
module dr_th22_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] q
);
    import dr_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_gate
        // Update one gate per sampling clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else
                q[i] <= hold_next(din[i] & en, ~din[i] & ~en, q[i]);
        end
    end

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~$past(q)) & ~$past(din & {W{en}})) == '0); // R9
    AST_FALL_NEEDS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q & $past(q)) & ($past(din) | {W{$past(en)}})) == '0); // R4
endmodule

// File: rtl/dr_done_detect.sv
// Completion detector: an OR per bit pair, merged by a W-input C-element.
// The output rises when all pairs are valid and falls when all are spacer.
// Assumes the pairs move monotonically within a phase.
module dr_done_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    output logic         done
);
    import dr_pkg::*;

    logic [W-1:0] bit_valid;

    for (genvar i = 0; i < W; i++) begin : g_or
        assign bit_valid[i] = r0[i] | r1[i];
    end

    // Emulated multi-input C-element.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= hold_next(&bit_valid, ~|bit_valid, done);
    end

    AST_ACK_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(&(r0 | r1))); // R5
    AST_ACK_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(~|(r0 | r1))); // R6
endmodule

// File: rtl/dr_pair_guard.sv
// Sticky detector for the illegal pair with both rails high at any input bit.
// Assumes only reset clears the flag.
module dr_pair_guard #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    output logic         err
);
    // Latch any illegal pair until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (|(r0 & r1))
            err <= 1'b1;
    end

    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r0 & r1)) |=> err); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8
endmodule

// File: rtl/dr_hold_stage.sv
// Dual-rail register stage: hysteresis storage on both rails, completion
// acknowledge, inverted request upstream and an illegal-pair flag.
// Assumes the neighbours follow the four-phase request/acknowledge order.
module dr_hold_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] up_rail0,
    input  logic [W-1:0] up_rail1,
    input  logic         dn_req,
    output logic [W-1:0] out_rail0,
    output logic [W-1:0] out_rail1,
    output logic         ack,
    output logic         up_req,
    output logic         pair_err
);
    dr_th22_bank #(.W(W)) u_rail0 (
        .clk(clk), .rst_n(rst_n), .din(up_rail0), .en(dn_req), .q(out_rail0));

    dr_th22_bank #(.W(W)) u_rail1 (
        .clk(clk), .rst_n(rst_n), .din(up_rail1), .en(dn_req), .q(out_rail1));

    dr_done_detect #(.W(W)) u_done (
        .clk(clk), .rst_n(rst_n), .r0(out_rail0), .r1(out_rail1), .done(ack));

    dr_pair_guard #(.W(W)) u_guard (
        .clk(clk), .rst_n(rst_n), .r0(up_rail0), .r1(up_rail1), .err(pair_err));

    // Request upstream is the inverse of the completion acknowledge.
    assign up_req = ~ack;

    AST_RESET_NULL: assert property (@(posedge clk)
        !rst_n |=> (out_rail0 == '0 && out_rail1 == '0 && !ack && !pair_err)); // R1
endmodule

// File: tb/sim_dr_hold_stage.sv
module sim_dr_hold_stage;
    localparam int W = 8;
    localparam int NTOK = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in0 = '0, in1 = '0;
    logic         dn_req = 1'b0;
    logic [W-1:0] out0, out1;
    logic         ack, up_req, pair_err;

    int checks = 0, fails = 0, cyc = 0;
    bit cmp_en = 1'b0;

    // Behavioural reference state.
    logic [W-1:0] m0 = '0, m1 = '0;
    logic         md = 1'b0, me = 1'b0;
    logic [W-1:0] sent_q[$];
    int           n_sent = 0, n_recv = 0;

    always #10 clk = ~clk;

    dr_hold_stage #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .up_rail0(in0), .up_rail1(in1), .dn_req(dn_req),
        .out_rail0(out0), .out_rail1(out1), .ack(ack), .up_req(up_req), .pair_err(pair_err));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model, one update per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m0 = '0; m1 = '0; md = 1'b0; me = 1'b0;
        end else begin
            int nc;
            nc = 0;
            for (int i = 0; i < W; i++) if (m0[i] | m1[i]) nc++;
            if (nc == W) md = 1'b1;
            else if (nc == 0) md = 1'b0;
            if ((in0 & in1) != '0) me = 1'b1;
            for (int i = 0; i < W; i++) begin
                if (in1[i] && dn_req) m1[i] = 1'b1;
                else if (!in1[i] && !dn_req) m1[i] = 1'b0;
                if (in0[i] && dn_req) m0[i] = 1'b1;
                else if (!in0[i] && !dn_req) m0[i] = 1'b0;
            end
        end
    end

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk({out0, out1} == {m0, m1}, "R2 held rails vs model", {out0, out1}, {m0, m1});
            chk(ack == md, "R5 ack vs model", ack, md);
            chk(up_req == ~md, "R7 up_req vs model", up_req, ~md);
            chk(pair_err == me, "R8 pair_err vs model", pair_err, me);
        end
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic nstep(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic producer();
        for (int t = 0; t < NTOK; t++) begin
            logic [W-1:0] v;
            while (!up_req) @(negedge clk);
            nstep($urandom_range(0, 3));
            v = W'($urandom);
            in1 = v; in0 = ~v;
            sent_q.push_back(v); n_sent++;
            while (up_req) @(negedge clk);
            nstep($urandom_range(0, 3));
            in0 = '0; in1 = '0;
        end
    endtask

    task automatic consumer();
        for (int t = 0; t < NTOK; t++) begin
            logic [W-1:0] exp;
            while ((out0 | out1) != {W{1'b1}}) @(negedge clk);
            exp = sent_q.pop_front();
            n_recv++;
            chk(out1 == exp, "R2 token order", out1, exp);
            nstep($urandom_range(0, 3));
            dn_req = 1'b0;
            while ((out0 | out1) != '0) @(negedge clk);
            nstep($urandom_range(0, 3));
            dn_req = 1'b1;
        end
    endtask

    initial begin
        nstep(5);
        chk(out0 == '0 && out1 == '0, "R1 rails null in reset", {out0, out1}, 0);
        chk(ack == 1'b0 && up_req == 1'b1, "R1 handshake in reset", {ack, up_req}, 2'b01);
        chk(pair_err == 1'b0, "R1 error clear in reset", pair_err, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R3: Data with request low is not captured.
        in1 = 8'h3C; in0 = ~8'h3C;
        nstep(3);
        chk(out0 == '0 && out1 == '0, "R3 no capture without request", {out0, out1}, 0);

        // R10: partial wavefront with request high.
        in1 = 8'h0C; in0 = 8'h03; in1[7:4] = '0; in0[7:4] = '0;
        dn_req = 1'b1;
        nstep(1);
        chk(out1 == 8'h0C && out0 == 8'h03, "R10 partial capture", {out0, out1}, {8'h03, 8'h0C});
        nstep(1);
        chk(ack == 1'b0, "R5 no ack on partial word", ack, 0);

        // R2 and R5: complete the word.
        in1 = 8'hAC; in0 = 8'h53;
        nstep(1);
        chk(out1 == 8'hAC && out0 == 8'h53, "R2 full capture", {out0, out1}, {8'h53, 8'hAC});
        chk(ack == 1'b0, "R5 ack one clock after completion", ack, 0);
        nstep(1);
        chk(ack == 1'b1 && up_req == 1'b0, "R5 R7 ack raised", {ack, up_req}, 2'b10);

        // R4: spacer at input while request high keeps the word.
        in0 = '0; in1 = '0;
        nstep(2);
        chk(out1 == 8'hAC && out0 == 8'h53, "R4 hold while request high", {out0, out1}, {8'h53, 8'hAC});

        // R6: half the word drains.
        in1 = 8'hA0; in0 = 8'h50;
        dn_req = 1'b0;
        nstep(1);
        chk(out1 == 8'hA0 && out0 == 8'h50, "R4 partial clear", {out0, out1}, {8'h50, 8'hA0});
        nstep(1);
        chk(ack == 1'b1, "R6 ack held on partial null", ack, 1);
        in0 = '0; in1 = '0;
        nstep(1);
        chk(out0 == '0 && out1 == '0, "R4 full clear", {out0, out1}, 0);
        nstep(1);
        chk(ack == 1'b0 && up_req == 1'b1, "R6 R7 ack dropped", {ack, up_req}, 2'b01);

        // R8: illegal pair, then sticky.
        in0 = 8'h04; in1 = 8'h04;
        nstep(1);
        chk(pair_err == 1'b1, "R8 illegal pair flagged", pair_err, 1);
        in0 = '0; in1 = '0;
        nstep(4);
        chk(pair_err == 1'b1, "R8 flag sticky", pair_err, 1);
        chk(out0 == '0 && out1 == '0 && ack == 1'b0, "R9 idle after illegal", {out0, out1, ack}, 0);

        // Randomized four-phase traffic.
        dn_req = 1'b1;
        fork
            producer();
            consumer();
        join
        nstep(4);
        chk(n_recv == n_sent && sent_q.size() == 0, "R4 no token lost or duplicated", n_recv, n_sent);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule